// File: doc/BRIEF.md
# Prescaled Up/Down Interval Timer

This block is a general-purpose interval timer with a counter of configurable width. A clock divider turns the system clock into count ticks. On each tick the counter steps by one, upward or downward as the control register selects. When the count sits at its end value (zero when counting down, all ones when counting up), the next tick is a timeout. A timeout sets a sticky status flag. The counter then either reloads from the load register (periodic mode) or wraps round (free-running mode). A rising edge on an external event pin copies the live count into a capture register and sets a second sticky flag. The interrupt line is high while either flag is set.

Software reaches the block through a flat word-addressed port. A write is one cycle with `bus_we` high, and a read is combinational on `bus_rdata`. Flags are cleared by writing ones to a dedicated clear address. Counting is controlled by a two-state machine:

- **ST_IDLE** is the state after reset. The counter holds its value.
- **START** (ST_IDLE to ST_RUN) is taken when the control register is written with the enable bit set. This transition loads the counter from the load register and zeroes the divider.
- **ST_RUN** counts whenever the clock-source field selects the synchronous clock.
- **STOP** (ST_RUN to ST_IDLE) is taken when the control register is written with the enable bit clear.

Writing the enable bit as 1 while already in ST_RUN keeps the machine in ST_RUN and does not reload the counter.

Top module: `gp_timer`

## Requirements
- R1: On each tick the count rises by one when control bit 2 is 1 and falls by one when it is 0. The reset value of bit 2 is 0 (count down).
- R2: Divider field control[1:0] gives one tick every 16 clocks for 01, every 64 for 10 and every 256 for 11.
- R3: Divider code 00 gives one tick per clock when control bit 15 is 1, and one tick every 4 clocks when it is 0.
- R4: Control bit 7 is the enable. Writing it as 1 from ST_IDLE loads the counter with the load value in that same edge and restarts the divider, so the first step comes exactly one divide period later. Writing it as 0 moves to ST_IDLE, after which the count holds.
- R5: A tick while the count is at its end value (0 when counting down, all ones when counting up) is a timeout. It sets status bit 0, which stays set until it is cleared.
- R6: With control bit 3 = 1 (periodic), a timeout loads the count with the load value.
- R7: With control bit 3 = 0 (free-running), a timeout wraps the count: up-counting goes to 0 and down-counting goes to all ones.
- R8: A rising edge of `cap_in` copies the count present before that edge into the capture register and sets status bit 1. A level that stays high produces no further captures.
- R9: At the clear address, a 1 in bit 0 clears status bit 0 and a 1 in bit 1 clears status bit 1. A 0 leaves the flag unchanged. A new event in the same cycle as the clear keeps its flag set.
- R10: `irq` is high exactly when status bit 0 or status bit 1 is set.
- R11: Counting happens only while the clock-source field control[6:5] is 00. Any other value holds the count while the machine is in ST_RUN.
- R12: Word addresses are: 0 control, 1 load, 2 count, 3 flag clear (reads 0), 4 status, 5 capture. After reset every register reads 0 and `irq` is low.
- R13: A write to the count address has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the only counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on `bus_addr` |
| cap_in | input | 1 | External event; a rising edge triggers a capture |
| irq | output | 1 | Interrupt request, the OR of the two status flags |

## Verification
The bench builds the timer with a 6-bit counter (`CNT_W = 6`) and the default 8-bit divider. With these values a terminal count is only 64 ticks away. This lets the bench run every pairing of direction and reload mode against four load values, including 0 and the all-ones end value, through more than two full timeouts each. It compares the count and the timeout flag with an arithmetic model on every cycle. The 8-bit divider keeps all five divide ratios, up to 256, cheap enough to time edge-exactly. The capture, the clear races, the source gating and the ignored count write then take only a handful of cycles each.

// File: rtl/gp_timer_pkg.sv
`timescale 1ns/1ps
package gp_timer_pkg;

    localparam int BUS_W  = 16;
    localparam int ADDR_W = 3;

    // Word addresses of the register file
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LOAD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd2;
    localparam logic [ADDR_W-1:0] A_ICLR  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CAPT  = 3'd5;

    // Control bit positions
    localparam int B_FAST = 15;
    localparam int B_EN   = 7;
    localparam int B_SRC  = 5;
    localparam int B_PER  = 3;
    localparam int B_UP   = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;

    typedef struct packed {
        logic       fast;
        logic       en;
        logic [1:0] src;
        logic       per;
        logic       up;
        logic [1:0] pre;
    } ctrl_t;

endpackage

// File: rtl/gp_timer_prescale.sv
`timescale 1ns/1ps
module gp_timer_prescale #(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic       fast,
    input  logic [1:0] pre,
    output logic       tick
);

    logic [PRE_W-1:0] pc_q;
    logic [PRE_W-1:0] last;

    // Terminal value of the divider for each code
    always_comb begin
        unique case (pre)
            2'b00:   last = fast ? PRE_W'(0) : PRE_W'(3);
            2'b01:   last = PRE_W'(15);
            2'b10:   last = PRE_W'(63);
            default: last = PRE_W'(255);
        endcase
    end

    assign tick = run && (pc_q >= last);

    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            pc_q <= '0;
        end else if (pc_q >= last) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + 1'b1;
        end
    end

endmodule

// File: rtl/gp_timer_counter.sv
`timescale 1ns/1ps
module gp_timer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_now,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             up,
    input  logic             periodic,
    output logic [CNT_W-1:0] count,
    output logic             tmo_evt
);

    logic at_end;

    assign at_end  = up ? (count == {CNT_W{1'b1}}) : (count == '0);
    assign tmo_evt = tick && at_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_now) begin
            count <= load_val;
        end else if (tick) begin
            if (at_end) begin
                count <= periodic ? load_val : (up ? '0 : {CNT_W{1'b1}});
            end else if (up) begin
                count <= count + 1'b1;
            end else begin
                count <= count - 1'b1;
            end
        end
    end

endmodule

// File: rtl/gp_timer_flags.sv
`timescale 1ns/1ps
module gp_timer_flags #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmo_evt,
    input  logic             cap_in,
    input  logic [CNT_W-1:0] count,
    input  logic             clr_tmo,
    input  logic             clr_cap,
    output logic             tmo_flag,
    output logic             cap_flag,
    output logic             cap_evt,
    output logic [CNT_W-1:0] cap_val
);

    logic cap_q;

    assign cap_evt = cap_in && !cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q    <= 1'b0;
            tmo_flag <= 1'b0;
            cap_flag <= 1'b0;
            cap_val  <= '0;
        end else begin
            cap_q <= cap_in;
            // a fresh event outranks a clear in the same cycle
            if (tmo_evt)      tmo_flag <= 1'b1;
            else if (clr_tmo) tmo_flag <= 1'b0;
            if (cap_evt) begin
                cap_flag <= 1'b1;
                cap_val  <= count;
            end else if (clr_cap) begin
                cap_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/gp_timer.sv
`timescale 1ns/1ps
module gp_timer
    import gp_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              cap_in,
    output logic              irq
);

    run_st_e          state_q, state_nx;
    ctrl_t            ctrl_q;
    logic [BUS_W-1:0] load_q;
    logic             ctrl_wr, load_wr;
    logic             clr_tmo, clr_cap;
    logic             state_run, load_now, run;
    logic             tick, tmo_evt;
    logic             tmo_flag, cap_flag, cap_evt;
    logic [CNT_W-1:0] count, cap_val;
    logic             unused_bits;

    assign unused_bits = ^{bus_wdata[14:8], bus_wdata[4]};

    assign ctrl_wr = bus_we && (bus_addr == A_CTRL);
    assign load_wr = bus_we && (bus_addr == A_LOAD);
    assign clr_tmo = bus_we && (bus_addr == A_ICLR) && bus_wdata[0];
    assign clr_cap = bus_we && (bus_addr == A_ICLR) && bus_wdata[1];

    // Control and load registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.fast <= bus_wdata[B_FAST];
                ctrl_q.en   <= bus_wdata[B_EN];
                ctrl_q.src  <= bus_wdata[B_SRC+1:B_SRC];
                ctrl_q.per  <= bus_wdata[B_PER];
                ctrl_q.up   <= bus_wdata[B_UP];
                ctrl_q.pre  <= bus_wdata[1:0];
            end
            if (load_wr) load_q <= bus_wdata;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Next-state logic: START and STOP transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (ctrl_wr &&  bus_wdata[B_EN]) state_nx = ST_RUN;
            ST_RUN:  if (ctrl_wr && !bus_wdata[B_EN]) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        state_run = 1'b0;
        load_now  = 1'b0;
        unique case (state_q)
            ST_IDLE: load_now  = (state_nx == ST_RUN);
            ST_RUN:  state_run = 1'b1;
            default: ;
        endcase
        run = state_run && (ctrl_q.src == 2'b00);
    end

    gp_timer_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (load_now),
        .fast    (ctrl_q.fast),
        .pre     (ctrl_q.pre),
        .tick    (tick)
    );

    gp_timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_now (load_now),
        .load_val (load_q[CNT_W-1:0]),
        .tick     (tick),
        .up       (ctrl_q.up),
        .periodic (ctrl_q.per),
        .count    (count),
        .tmo_evt  (tmo_evt)
    );

    gp_timer_flags #(.CNT_W(CNT_W)) u_flg (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmo_evt  (tmo_evt),
        .cap_in   (cap_in),
        .count    (count),
        .clr_tmo  (clr_tmo),
        .clr_cap  (clr_cap),
        .tmo_flag (tmo_flag),
        .cap_flag (cap_flag),
        .cap_evt  (cap_evt),
        .cap_val  (cap_val)
    );

    assign irq = tmo_flag || cap_flag;

    // Register read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_FAST]          = ctrl_q.fast;
                bus_rdata[B_EN]            = ctrl_q.en;
                bus_rdata[B_SRC+1:B_SRC]   = ctrl_q.src;
                bus_rdata[B_PER]           = ctrl_q.per;
                bus_rdata[B_UP]            = ctrl_q.up;
                bus_rdata[1:0]             = ctrl_q.pre;
            end
            A_LOAD:  bus_rdata = load_q;
            A_COUNT: bus_rdata = BUS_W'(count);
            A_STAT:  bus_rdata = {{(BUS_W-2){1'b0}}, cap_flag, tmo_flag};
            A_CAPT:  bus_rdata = BUS_W'(cap_val);
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gp_timer_chk.sv
`timescale 1ns/1ps
module gp_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             state_run,
    input logic             tick,
    input logic             load_now,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] load_val,
    input logic             up,
    input logic             periodic,
    input logic [1:0]       src,
    input logic             tmo_evt,
    input logic             tmo_flag,
    input logic             cap_flag,
    input logic             cap_evt,
    input logic [CNT_W-1:0] cap_val,
    input logic             clr_tmo
);

    p_step_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && up && !tmo_evt) |=> count == CNT_W'($past(count) + 1'b1));

    p_step_dn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !up && !tmo_evt) |=> count == CNT_W'($past(count) - 1'b1));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_now) |=> $stable(count));

    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_now |=> (state_run && count == $past(load_val)));

    p_tmo_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_evt |=> tmo_flag);

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_evt && periodic) |=> count == $past(load_val));

    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_evt && !periodic) |=> count == (up ? '0 : {CNT_W{1'b1}}));

    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_flag && cap_val == $past(count)));

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !clr_tmo) |=> tmo_flag);

    p_src_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (state_run && src == 2'b00));

endmodule

bind gp_timer gp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_run (state_run),
    .tick      (tick),
    .load_now  (load_now),
    .count     (count),
    .load_val  (load_q[CNT_W-1:0]),
    .up        (ctrl_q.up),
    .periodic  (ctrl_q.per),
    .src       (ctrl_q.src),
    .tmo_evt   (tmo_evt),
    .tmo_flag  (tmo_flag),
    .cap_flag  (cap_flag),
    .cap_evt   (cap_evt),
    .cap_val   (cap_val),
    .clr_tmo   (clr_tmo)
);

// File: tb/tb_gp_timer.sv
`timescale 1ns/1ps
module tb_gp_timer;

    localparam int CW   = 6;
    localparam int MAXV = (1 << CW) - 1;

    localparam logic [2:0] AD_CTRL = 3'd0, AD_LOAD = 3'd1, AD_COUNT = 3'd2,
                           AD_ICLR = 3'd3, AD_STAT = 3'd4, AD_CAPT  = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        cap_in;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    gp_timer #(.CNT_W(CW), .PRE_W(8)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_in    (cap_in),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, c0, c1;
        int loads [4] = '{0, 5, 62, 63};

        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; cap_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        rd(AD_CTRL, v);  check("R12 ctrl", v, 16'h0);
        rd(AD_LOAD, v);  check("R12 load", v, 16'h0);
        rd(AD_COUNT, v); check("R12 count", v, 16'h0);
        rd(AD_STAT, v);  check("R12 stat", v, 16'h0);
        rd(AD_CAPT, v);  check("R12 capt", v, 16'h0);
        check("R12 irq", 16'(irq), 16'h0);

        // R1 R5 R6 R7: sweep of direction x mode x load, divide by 1
        for (int up = 0; up < 2; up++) begin
            for (int per = 0; per < 2; per++) begin
                for (int li = 0; li < 4; li++) begin
                    int ld = loads[li];
                    int m_cnt, m_tmo, term;
                    string rq;
                    term = up ? MAXV : 0;
                    rq = per ? "R6/R1" : "R7/R1";
                    wr(AD_CTRL, 16'h0);
                    wr(AD_ICLR, 16'h3);
                    wr(AD_LOAD, 16'(ld));
                    wr(AD_CTRL, 16'(16'h8080 | (per << 3) | (up << 2)));
                    m_cnt = ld;
                    m_tmo = 0;
                    for (int k = 0; k < 140; k++) begin
                        rd(AD_COUNT, v); check(rq, v, 16'(m_cnt));
                        rd(AD_STAT, v);  check("R5 tmo flag", v & 16'h1, 16'(m_tmo));
                        cyc(1);
                        if (m_cnt == term) begin
                            m_tmo = 1;
                            m_cnt = per ? ld : (up ? 0 : MAXV);
                        end else begin
                            m_cnt = (m_cnt + (up ? 1 : -1)) & MAXV;
                        end
                    end
                    // STOP: the write edge still counts once
                    wr(AD_CTRL, 16'h0);
                    if (m_cnt == term) m_cnt = per ? ld : (up ? 0 : MAXV);
                    else               m_cnt = (m_cnt + (up ? 1 : -1)) & MAXV;
                    for (int k = 0; k < 4; k++) begin
                        rd(AD_COUNT, v); check("R4 hold", v, 16'(m_cnt));
                        cyc(1);
                    end
                end
            end
        end

        // R2 R3 R4: divide ratios, first step exactly one period after start
        for (int i = 0; i < 5; i++) begin
            int div;
            logic [15:0] cv;
            div = (i == 0) ? 1 : (4 << (2 * (i - 1)));
            cv  = 16'(((i == 0) ? 16'h8000 : 16'h0) | 16'h0084 | ((i == 0) ? 0 : (i - 1)));
            wr(AD_CTRL, 16'h0);
            wr(AD_LOAD, 16'h0);
            wr(AD_CTRL, cv);
            cyc(div - 1);
            rd(AD_COUNT, v); check((i < 2) ? "R3 before step" : "R2 before step", v, 16'h0);
            cyc(1);
            rd(AD_COUNT, v); check((i < 2) ? "R3 first step" : "R2 first step", v, 16'h1);
            cyc(div);
            rd(AD_COUNT, v); check((i < 2) ? "R3 second step" : "R2 second step", v, 16'h2);
        end

        // R8 R10: capture while counting up from 20
        wr(AD_CTRL, 16'h0);
        wr(AD_ICLR, 16'h3);
        wr(AD_LOAD, 16'd20);
        wr(AD_CTRL, 16'h8084);
        cyc(3);
        rd(AD_COUNT, c0);
        check("R1 count before capture", c0, 16'd23);
        cap_in = 1'b1;
        cyc(1);
        rd(AD_CAPT, v); check("R8 capture value", v, c0);
        rd(AD_STAT, v); check("R8 capture flag", v, 16'h2);
        check("R10 irq on capture", 16'(irq), 16'h1);
        cyc(3);
        rd(AD_CAPT, v); check("R8 held level no recapture", v, c0);
        cap_in = 1'b0;

        // R9: zero write has no effect
        wr(AD_ICLR, 16'h0);
        rd(AD_STAT, v); check("R9 zero write", v, 16'h2);
        // R9: new capture in the clearing cycle wins
        rd(AD_COUNT, c1);
        cap_in = 1'b1;
        wr(AD_ICLR, 16'h2);
        cap_in = 1'b0;
        rd(AD_STAT, v); check("R9 event beats clear", v, 16'h2);
        rd(AD_CAPT, v); check("R8 second capture", v, c1);
        wr(AD_ICLR, 16'h2);
        rd(AD_STAT, v); check("R9 capture clear", v, 16'h0);
        check("R10 irq low", 16'(irq), 16'h0);

        // R5 R9 R10: timeout flag set and cleared on its own bit
        cyc(40);
        rd(AD_STAT, v); check("R5 timeout flag", v, 16'h1);
        check("R10 irq on timeout", 16'(irq), 16'h1);
        wr(AD_ICLR, 16'h2);
        rd(AD_STAT, v); check("R9 wrong bit keeps flag", v, 16'h1);
        wr(AD_ICLR, 16'h1);
        rd(AD_STAT, v); check("R9 timeout clear", v, 16'h0);
        check("R10 irq cleared", 16'(irq), 16'h0);

        // R13: count address ignores writes
        wr(AD_CTRL, 16'h0);
        rd(AD_COUNT, c0);
        wr(AD_COUNT, 16'h0015);
        rd(AD_COUNT, v); check("R13 count write ignored", v, c0);

        // R11: non-zero clock source holds the count
        wr(AD_LOAD, 16'd7);
        wr(AD_CTRL, 16'h80A4);
        cyc(10);
        rd(AD_COUNT, v); check("R11 hold with source 01", v, 16'd7);
        wr(AD_CTRL, 16'h8084);
        rd(AD_COUNT, v); check("R11 no reload on enable in run", v, 16'd7);
        cyc(1);
        rd(AD_COUNT, v); check("R11 resumes with source 00", v, 16'd8);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule